// File: doc/BRIEF.md
# Sound Channel Length Counter

This block keeps the note-length count of one sound channel and asks for the channel to be switched off when that count runs out. Software writes a load value L through the length write path. The count then starts at 2^LEN_W − L. Each length clock from an external frame sequencer lowers the count by one, but only while length counting is enabled. When the count reaches zero, the block raises a one-cycle disable request.

A control write carries two things: the new length-enable bit and an optional trigger. A further input, `skip_next`, tells the block that the sequencer's next step will not clock length. Two corner cases depend on this flag when a control write arrives:

- If the write turns length counting on (a 0-to-1 edge of the enable bit), the count takes one extra decrement.
- If the write triggers the channel with length enabled and the count ends up full, the count is loaded one lower.

The sequencer itself is outside this block.

Top module: `len_counter`

## Requirements
- R1: A synchronous active-high reset sets the count to 0, clears the disable request and clears the length-enable state.
- R2: A length write with load L sets the count to 2^LEN_W − L one cycle later; L = 0 gives the full value 64 when LEN_W = 6.
- R3: A length clock lowers the count by one only when length is enabled and the count is nonzero; otherwise the count is unchanged.
- R4: When a length clock brings the count to zero, `kill_o` is 1 for exactly one cycle, in the same cycle that `cnt_o` first shows 0.
- R5: A control write with trigger set reloads a zero count to the full value and leaves a nonzero count as it is.
- R6: A control write with `skip_next` = 1 takes the count down by one extra step when three things hold: enable was 0 before the write, the written enable bit is 1, and the count is nonzero.
- R7: If that extra decrement reaches zero and the same write does not trigger, `kill_o` pulses for one cycle; a trigger in the same write suppresses the pulse.
- R8: A trigger write with `skip_next` = 1 and the written enable bit = 1 that leaves the count at the full value loads full − 1 instead; with `skip_next` = 0 the count stays full.
- R9: Within one control write, the extra decrement is applied before the trigger reload. A count of 1 with an enabling, triggering write and `skip_next` = 1 therefore ends at full − 1.
- R10: When several requests arrive in one cycle, only one takes effect. Control writes come first, then length writes, then length clocks; the others are ignored.
- R11: Every control write stores its enable bit. Turning enable on with `skip_next` = 0 does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_wr | input | 1 | Length write strobe |
| load_val | input | LEN_W | Length load value L |
| ctl_wr | input | 1 | Control write strobe |
| ctl_len_en | input | 1 | Length-enable bit of the control write |
| ctl_trig | input | 1 | Trigger bit of the control write |
| len_clk | input | 1 | Length clock pulse from the frame sequencer |
| skip_next | input | 1 | Next sequencer step does not clock length |
| cnt_o | output | LEN_W+1 | Current count |
| kill_o | output | 1 | One-cycle channel disable request |

## Verification
The bench builds the block with the default LEN_W = 6, so the full value is 64. At that size, loading 63 puts a count of 1 just one write away. This brings every path to zero within reach in a few cycles: a length clock, the enable-edge decrement, and the decrement followed by a trigger reload. Random traffic with colliding strobes, mixed with these directed cases, exercises the priority order and the full-value adjustment at both ends of the count range.

// File: rtl/len_counter.sv
module len_counter #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_wr,
  input  logic [LEN_W-1:0] load_val,
  input  logic             ctl_wr,
  input  logic             ctl_len_en,
  input  logic             ctl_trig,
  input  logic             len_clk,
  input  logic             skip_next,
  output logic [LEN_W:0]   cnt_o,
  output logic             kill_o
);
  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1 << LEN_W);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en_q, kill_q, kill_d;

  always_comb begin
    cnt_d  = cnt_q;
    kill_d = 1'b0;
    if (ctl_wr) begin
      if (skip_next && !en_q && ctl_len_en && cnt_q != '0) begin
        cnt_d  = cnt_q - ONE;
        kill_d = (cnt_d == '0);
      end
      if (ctl_trig) begin
        kill_d = 1'b0;
        if (cnt_d == '0) cnt_d = FULL;
        if (skip_next && ctl_len_en && cnt_d == FULL) cnt_d = FULL - ONE;
      end
    end else if (load_wr) begin
      cnt_d = FULL - {1'b0, load_val};
    end else if (len_clk && en_q && cnt_q != '0) begin
      cnt_d  = cnt_q - ONE;
      kill_d = (cnt_q == ONE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      en_q   <= 1'b0;
      kill_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      kill_q <= kill_d;
      if (ctl_wr) en_q <= ctl_len_en;
    end
  end

  assign cnt_o  = cnt_q;
  assign kill_o = kill_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) cnt_q <= FULL); // R2
  AST_KILL_AT_ZERO: assert property (@(posedge clk) disable iff (rst) kill_q |-> cnt_q == '0); // R4
  AST_KILL_SINGLE: assert property (@(posedge clk) disable iff (rst) kill_q |=> !kill_q); // R4
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (load_wr && !ctl_wr) |=> cnt_q == FULL - {1'b0, $past(load_val)}); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ctl_wr && !load_wr && (!len_clk || !en_q)) |=> $stable(cnt_q)); // R3
  AST_TRIG_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_trig) |=> (cnt_q != '0 && !kill_q)); // R5
endmodule

// File: tb/len_counter_test.sv
module len_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 6;
  localparam int FULL = 1 << LEN_W;

  logic clk = 0, rst = 1;
  logic load_wr = 0, ctl_wr = 0, ctl_len_en = 0, ctl_trig = 0, len_clk = 0, skip_next = 0;
  logic [LEN_W-1:0] load_val = '0;
  logic [LEN_W:0] cnt_o;
  logic kill_o;

  int checks = 0, errors = 0, cycles = 0;
  int m_cnt = 0;
  bit m_en = 0, m_kill = 0, done = 0;

  len_counter #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rst(rst), .load_wr(load_wr), .load_val(load_val),
    .ctl_wr(ctl_wr), .ctl_len_en(ctl_len_en), .ctl_trig(ctl_trig),
    .len_clk(len_clk), .skip_next(skip_next), .cnt_o(cnt_o), .kill_o(kill_o));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles++;

  function automatic void model(bit lw, int lv, bit cw, bit le, bit tr, bit lc, bit sk);
    m_kill = 0;
    if (cw) begin
      if (sk && !m_en && le && m_cnt != 0) begin m_cnt--; m_kill = (m_cnt == 0); end
      if (tr) begin
        m_kill = 0;
        if (m_cnt == 0) m_cnt = FULL;
        if (sk && le && m_cnt == FULL) m_cnt = FULL - 1;
      end
      m_en = le;
    end else if (lw) m_cnt = FULL - lv;
    else if (lc && m_en && m_cnt != 0) begin m_cnt--; m_kill = (m_cnt == 0); end
  endfunction

  task automatic chk(string tag);
    checks++;
    if (int'(cnt_o) != m_cnt || kill_o != m_kill) begin
      errors++;
      $display("FAIL %s: cnt=%0d kill=%0b expected cnt=%0d kill=%0b", tag, cnt_o, kill_o, m_cnt, m_kill);
    end
  endtask

  task automatic cyc(bit lw, int lv, bit cw, bit le, bit tr, bit lc, bit sk, string tag);
    load_wr = lw; load_val = LEN_W'(lv); ctl_wr = cw; ctl_len_en = le;
    ctl_trig = tr; len_clk = lc; skip_next = sk;
    model(lw, lv, cw, le, tr, lc, sk);
    @(posedge clk); @(negedge clk);
    chk(tag);
  endtask

  task automatic load(int v, string t);         cyc(1, v, 0, 0, 0, 0, 0, t); endtask
  task automatic ctl(bit le, bit tr, bit sk, string t); cyc(0, 0, 1, le, tr, 0, sk, t); endtask
  task automatic tick(string t);                cyc(0, 0, 0, 0, 0, 1, 0, t); endtask
  task automatic idle(string t);                cyc(0, 0, 0, 0, 0, 0, 0, t); endtask

  initial begin
    void'($urandom(32'h5eed_0a17));
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 reset state");
    load(63, "R2 load 63 gives 1");
    tick("R1 enable clear after reset, no decrement");
    ctl(1, 0, 0, "R11 enable without flag no change");
    tick("R3 R4 clock to zero with kill");
    idle("R4 kill lasts one cycle");
    tick("R3 no decrement at zero");
    ctl(1, 1, 0, "R5 trigger reloads zero to full");
    ctl(1, 1, 0, "R5 trigger keeps nonzero count");
    load(0, "R2 load 0 gives full");
    load(60, "R2 load 60");
    ctl(0, 0, 0, "R11 disable");
    ctl(1, 0, 1, "R6 enable edge extra decrement");
    ctl(1, 0, 1, "R6 no edge no decrement");
    load(63, "R2 load 63");
    ctl(0, 0, 0, "R11 disable");
    ctl(1, 0, 1, "R7 edge decrement to zero kills");
    load(63, "R2 load 63");
    ctl(0, 0, 0, "R11 disable");
    ctl(1, 1, 1, "R9 R7 decrement then reload then adjust, no kill");
    load(0, "R2 load full");
    ctl(1, 1, 1, "R8 full becomes full-1");
    load(0, "R2 load full");
    ctl(1, 1, 0, "R8 no flag keeps full");
    cyc(1, 10, 1, 1, 0, 0, 0, "R10 control wins over length write");
    cyc(1, 62, 0, 0, 0, 1, 0, "R10 length write wins over clock");
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 16;
      cyc(r < 3, (r == 0) ? 63 - ($urandom % 4) : $urandom % FULL,
          r >= 3 && r < 6, $urandom % 2, ($urandom % 3) == 0,
          r >= 5, $urandom % 2, "R10 random traffic");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule